// File: doc/BRIEF.md
# Coprocessor Escape Intercept Sequencer

This block sits on the data path between a host CPU and its memory. It tags every bus cycle by the host's two status lines: program-fetch (VPA) and data-valid (VDA). When the CPU fetches the coprocessor-escape opcode, the block hides that opcode from the CPU. It then feeds the CPU a fast two-byte no-op, $42, on each instruction-stream read. While it does this, it collects the bytes of the escape sequence from the stream: a command byte, then the low, middle and bank bytes of a 24-bit operand address.

Once it has the bank byte, the block pulls the ready and bus-enable lines low in the same cycle. This stops the CPU and releases the bus. The block then becomes bus master. It drives the operand address for a read and fetches one to four bytes, one per cycle, at consecutive addresses. It packs these bytes into a 32-bit cell and pushes the cell onto an internal stack of eight cells. After that it hands the bus back to the CPU.

A CPU with this block attached runs escape sequences as plain no-ops. The coprocessor side receives the operand without any extra CPU instructions.

Top module: `copEscapeSeq`

## Requirements
- R1: While reset is held, and after it is released: ready and bus-enable are high, the address driver is off, the substitute driver is off, the stack depth is 0, the overflow flag is 0 and the top-of-stack output is 0.
- R2: While idle, memory data passes to the CPU unchanged and the substitute driver stays off. This includes byte $02 on a cycle that is not an opcode fetch, and byte $02 on a write cycle. Neither of these cycles starts a sequence.
- R3: An opcode fetch (VPA=1, VDA=1, read) carrying byte $02 while idle starts a sequence. In that same cycle the CPU receives $42 in place of $02.
- R4: After the trigger, the next four reads with VPA=1 are captured in this order: command byte, address bits 7:0, address bits 15:8, address bits 23:16. Each of them reaches the CPU as $42. A read with VPA=0 during capture is not counted and passes memory data through.
- R5: From the cycle after the bank byte is captured, ready and bus-enable are both low. The block drives the captured 24-bit address with the read/write line high and the address driver enabled, and holds this until the last byte has been read.
- R6: The burst reads N = (command bits 1:0) + 1 bytes, one per cycle. The address rises by one each cycle and carries across all 24 bits, wrapping from $FFFFFF to $000000. The other command bits do not affect N.
- R7: Burst byte k goes to bits 8k+7:8k of the cell, so the first byte read is the low byte. Lanes that were not read are zero. The cell is pushed onto the stack, the depth rises by one, the top-of-stack output shows the cell, and ready and bus-enable are high again in the cycle after the last read.
- R8: The stack holds 8 cells. A push onto a full stack discards the value, leaves the depth at 8 and the top unchanged, and sets an overflow flag. The flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| vpa | input | 1 | CPU status: instruction-stream access |
| vda | input | 1 | CPU status: data-valid access |
| rwN | input | 1 | CPU read/write, high for read |
| memDataIn | input | 8 | Data returned by memory |
| cpuDataOut | output | 8 | Data presented to the CPU |
| cpuSubst | output | 1 | Substitute driver enable (no-op on the CPU data input) |
| rdy | output | 1 | CPU ready, low halts the CPU |
| be | output | 1 | CPU bus enable, low floats the CPU bus |
| busAddr | output | 24 | Address driven while bus master |
| busAddrEn | output | 1 | Address and read/write driver enable |
| busRwN | output | 1 | Read/write line driven while master (always read) |
| stackTop | output | 32 | Most recently pushed cell, 0 when empty |
| stackDepth | output | 4 | Number of stored cells |
| stackOverflow | output | 1 | Sticky push-when-full flag |

## Verification
The capture-and-burst sequence is run with every command length code and with spare upper command bits set. Address bases are chosen so the burst carries out of the low byte, out of the middle byte, and out of the full 24-bit range. These cases separate a correct address increment and lane order from ones that stop at a byte boundary or reverse the packing. One sequence includes a data-only read in the middle of capture, which shows whether capture counts only instruction-stream reads. Byte $02 is also presented on operand fetches, data reads and writes while idle, which shows that only a true opcode fetch triggers. Nine pushes in total show the overflow point and that the flag stays set.

// File: rtl/copSeqPkg.sv
`timescale 1ns/1ps
package copSeqPkg;
  localparam logic [7:0] OPC_ESC    = 8'h02;
  localparam logic [7:0] OPC_FILL   = 8'h42;
  localparam int         CELL_BYTES = 4;
  localparam int         CELL_W     = CELL_BYTES * 8;
  localparam int         LANE_W     = $clog2(CELL_BYTES);
  localparam int         ADDR_W     = 24;

  typedef enum logic [1:0] {ST_IDLE, ST_CAP, ST_READ} seqState_t;

  typedef struct packed {
    logic              loadIr;
    logic              loadLo;
    logic              loadHi;
    logic              loadBank;
    logic              readByte;
    logic              push;
    logic [LANE_W-1:0] lane;
  } dpCtl_t;
endpackage

// File: rtl/copSeqCtrl.sv
`timescale 1ns/1ps
module copSeqCtrl
  import copSeqPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              vpa,
  input  logic              vda,
  input  logic              rwN,
  input  logic [7:0]        dataIn,
  input  logic [LANE_W-1:0] lenCode,
  output dpCtl_t            ctl,
  output logic              subst,
  output logic              halted
);
  seqState_t         state;
  logic [1:0]        capIdx;
  logic [LANE_W-1:0] byteCnt;
  logic              trig;
  logic              streamRd;

  assign streamRd = vpa && rwN;
  assign trig     = (state == ST_IDLE) && vpa && vda && rwN && (dataIn == OPC_ESC);
  assign subst    = trig || ((state == ST_CAP) && streamRd);
  assign halted   = (state == ST_READ);

  always_comb begin
    ctl = '0;
    if (state == ST_CAP && streamRd) begin
      case (capIdx)
        2'd0:    ctl.loadIr   = 1'b1;
        2'd1:    ctl.loadLo   = 1'b1;
        2'd2:    ctl.loadHi   = 1'b1;
        default: ctl.loadBank = 1'b1;
      endcase
    end
    if (state == ST_READ) begin
      ctl.readByte = 1'b1;
      ctl.lane     = byteCnt;
      ctl.push     = (byteCnt == lenCode);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      capIdx  <= '0;
      byteCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: if (trig) begin
          state  <= ST_CAP;
          capIdx <= '0;
        end
        ST_CAP: if (streamRd) begin
          capIdx <= capIdx + 2'd1;
          if (capIdx == 2'd3) begin
            state   <= ST_READ;
            byteCnt <= '0;
          end
        end
        ST_READ: begin
          if (ctl.push) state <= ST_IDLE;
          else          byteCnt <= byteCnt + LANE_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R5: bank capture is followed by a halted bus
  a_r5_halt_after_bank: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CAP && streamRd && capIdx == 2'd3) |=> halted);

  // R7: the CPU gets the bus back right after the push
  a_r7_release_after_push: assert property (@(posedge clk) disable iff (!rstN)
    (halted && ctl.push) |=> !halted);

  // R4: non-stream cycles during capture are not substituted
  a_r4_gap_not_substituted: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CAP && !vpa) |-> !subst);
endmodule

// File: rtl/copSeqDp.sv
`timescale 1ns/1ps
module copSeqDp
  import copSeqPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [7:0]        dataIn,
  output logic [LANE_W-1:0] lenCode,
  output logic [ADDR_W-1:0] ptr,
  output logic [CELL_W-1:0] pushVal
);
  logic [7:0]        cmdReg;
  logic [CELL_W-1:0] acc;
  logic [7:0]        laneVal [CELL_BYTES];

  assign lenCode = cmdReg[LANE_W-1:0];

  for (genvar g = 0; g < CELL_BYTES; g++) begin : gLane
    assign laneVal[g] = (ctl.readByte && ctl.lane == LANE_W'(g)) ? dataIn : acc[g*8 +: 8];
  end

  always_comb begin
    for (int i = 0; i < CELL_BYTES; i++) pushVal[i*8 +: 8] = laneVal[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdReg <= '0;
      ptr    <= '0;
      acc    <= '0;
    end else begin
      if (ctl.loadIr)   cmdReg      <= dataIn;
      if (ctl.loadLo)   ptr[7:0]    <= dataIn;
      if (ctl.loadHi)   ptr[15:8]   <= dataIn;
      if (ctl.loadBank) begin
        ptr[23:16] <= dataIn;
        acc        <= '0;
      end
      if (ctl.readByte) begin
        acc <= pushVal;
        ptr <= ptr + ADDR_W'(1);
      end
    end
  end

  // R6: consecutive burst reads step the address by one
  a_r6_addr_step: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.readByte && $past(ctl.readByte)) |-> ptr == $past(ptr) + ADDR_W'(1));

  // R7: consecutive burst bytes land in rising lanes
  a_r7_lane_order: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.readByte && $past(ctl.readByte)) |-> ctl.lane == $past(ctl.lane) + LANE_W'(1));
endmodule

// File: rtl/copSeqStack.sv
`timescale 1ns/1ps
module copSeqStack #(
  parameter int CELL_W = 32,
  parameter int DEPTH  = 8,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              push,
  input  logic [CELL_W-1:0] pushVal,
  output logic [CELL_W-1:0] top,
  output logic [CNT_W-1:0]  depth,
  output logic              overflow
);
  logic [CELL_W-1:0] cells [DEPTH];
  logic              full;
  logic [IDX_W-1:0]  topIdx;

  assign full   = (depth == CNT_W'(DEPTH));
  assign topIdx = IDX_W'(depth - CNT_W'(1));
  assign top    = (depth == '0) ? '0 : cells[topIdx];

  always_ff @(posedge clk) begin
    if (push && !full) cells[IDX_W'(depth)] <= pushVal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      depth    <= '0;
      overflow <= 1'b0;
    end else if (push) begin
      if (full) overflow <= 1'b1;
      else      depth    <= depth + CNT_W'(1);
    end
  end

  // R8: the overflow flag never clears outside reset
  a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (!rstN)
    $past(overflow) |-> overflow);

  // R8: depth stays within capacity
  a_r8_depth_bound: assert property (@(posedge clk) disable iff (!rstN)
    depth <= CNT_W'(DEPTH));

  // R8: a push onto a full stack keeps the depth
  a_r8_full_holds: assert property (@(posedge clk) disable iff (!rstN)
    (push && full) |=> depth == $past(depth));

  // R7: a push onto a non-full stack adds one cell
  a_r7_push_grows: assert property (@(posedge clk) disable iff (!rstN)
    (push && !full) |=> depth == $past(depth) + CNT_W'(1));
endmodule

// File: rtl/copEscapeSeq.sv
`timescale 1ns/1ps
module copEscapeSeq
  import copSeqPkg::*;
#(
  parameter int STACK_DEPTH = 8
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             vpa,
  input  logic                             vda,
  input  logic                             rwN,
  input  logic [7:0]                       memDataIn,
  output logic [7:0]                       cpuDataOut,
  output logic                             cpuSubst,
  output logic                             rdy,
  output logic                             be,
  output logic [23:0]                      busAddr,
  output logic                             busAddrEn,
  output logic                             busRwN,
  output logic [31:0]                      stackTop,
  output logic [$clog2(STACK_DEPTH+1)-1:0] stackDepth,
  output logic                             stackOverflow
);
  dpCtl_t            ctl;
  logic              subst;
  logic              halted;
  logic [LANE_W-1:0] lenCode;
  logic [ADDR_W-1:0] ptr;
  logic [CELL_W-1:0] pushVal;

  copSeqCtrl uCtrl (
    .clk(clk), .rstN(rstN), .vpa(vpa), .vda(vda), .rwN(rwN),
    .dataIn(memDataIn), .lenCode(lenCode),
    .ctl(ctl), .subst(subst), .halted(halted)
  );

  copSeqDp uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .dataIn(memDataIn),
    .lenCode(lenCode), .ptr(ptr), .pushVal(pushVal)
  );

  copSeqStack #(.CELL_W(CELL_W), .DEPTH(STACK_DEPTH)) uStack (
    .clk(clk), .rstN(rstN), .push(ctl.push), .pushVal(pushVal),
    .top(stackTop), .depth(stackDepth), .overflow(stackOverflow)
  );

  assign cpuSubst   = subst;
  assign cpuDataOut = subst ? OPC_FILL : memDataIn;
  assign rdy        = ~halted;
  assign be         = ~halted;
  assign busAddrEn  = halted;
  assign busAddr    = ptr;
  assign busRwN     = 1'b1;
endmodule

// File: tb/sim_copEscapeSeq.sv
`timescale 1ns/1ps
module sim_copEscapeSeq;
  logic        clk = 1'b0;
  logic        rstN;
  logic        vpa, vda, rwN;
  logic [7:0]  streamData;
  logic [7:0]  memDataIn;
  logic [7:0]  cpuDataOut;
  logic        cpuSubst, rdy, be, busAddrEn, busRwN, stackOverflow;
  logic [23:0] busAddr;
  logic [31:0] stackTop;
  logic [3:0]  stackDepth;

  int nChecks = 0;
  int nFail   = 0;
  int expDepth = 0;
  logic [31:0] expTop = '0;

  always #2 clk = ~clk;

  function automatic logic [7:0] memByte(input logic [23:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ a[23:16] ^ 8'hA5;
  endfunction

  assign memDataIn = busAddrEn ? memByte(busAddr) : streamData;

  copEscapeSeq u0 (
    .clk(clk), .rstN(rstN), .vpa(vpa), .vda(vda), .rwN(rwN),
    .memDataIn(memDataIn), .cpuDataOut(cpuDataOut), .cpuSubst(cpuSubst),
    .rdy(rdy), .be(be), .busAddr(busAddr), .busAddrEn(busAddrEn),
    .busRwN(busRwN), .stackTop(stackTop), .stackDepth(stackDepth),
    .stackOverflow(stackOverflow)
  );

  // command byte and 24-bit address
  localparam logic [31:0] VEC [6] = '{
    {8'h03, 24'h123456},
    {8'h00, 24'h00ABCD},
    {8'h01, 24'h7F00FF},
    {8'h02, 24'h01FFFF},
    {8'h07, 24'hFFFFFE},
    {8'hFC, 24'h400000}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic d, input logic rw, input logic [7:0] data);
    @(negedge clk);
    vpa = v; vda = d; rwN = rw; streamData = data;
    #1;
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  task automatic runEscape(input logic [7:0] cmd, input logic [23:0] addr, input bit withGap);
    int n;
    logic [31:0] val;
    n   = int'(cmd[1:0]) + 1;
    val = '0;
    for (int k = 0; k < n; k++) val[k*8 +: 8] = memByte(addr + 24'(k));

    drive(1, 1, 1, 8'h02);
    check(cpuDataOut == 8'h42 && cpuSubst, "R3 trigger substituted", {24'h0, cpuDataOut}, 32'h42);
    drive(1, 0, 1, cmd);
    check(cpuDataOut == 8'h42 && cpuSubst, "R4 command byte", {24'h0, cpuDataOut}, 32'h42);
    drive(1, 1, 1, addr[7:0]);
    check(cpuDataOut == 8'h42, "R4 address low", {24'h0, cpuDataOut}, 32'h42);
    if (withGap) begin
      drive(0, 1, 1, 8'h02);
      check(cpuDataOut == 8'h02 && !cpuSubst, "R4 gap cycle passes", {24'h0, cpuDataOut}, 32'h02);
    end
    drive(1, 0, 1, addr[15:8]);
    check(cpuDataOut == 8'h42, "R4 address high", {24'h0, cpuDataOut}, 32'h42);
    drive(1, 1, 1, addr[23:16]);
    check(cpuDataOut == 8'h42 && rdy && be, "R4 bank byte", {24'h0, cpuDataOut}, 32'h42);

    for (int k = 0; k < n; k++) begin
      drive(0, 0, 1, 8'h00);
      check(!rdy && !be && busAddrEn && busRwN, "R5 halted master read", {28'h0, rdy, be, busAddrEn, busRwN}, 32'h3);
      check(busAddr == addr + 24'(k), "R6 burst address", {8'h0, busAddr}, {8'h0, addr + 24'(k)});
    end

    if (expDepth < 8) begin
      expDepth++;
      expTop = val;
    end
    drive(1, 1, 1, 8'hEA);
    check(rdy && be && !busAddrEn, "R7 bus released", {29'h0, rdy, be, busAddrEn}, 32'h6);
    check(cpuDataOut == 8'hEA && !cpuSubst, "R2 pass-through after release", {24'h0, cpuDataOut}, 32'hEA);
    check(stackTop == expTop, "R7 pushed cell", stackTop, expTop);
    check(int'(stackDepth) == expDepth, "R7 depth", {28'h0, stackDepth}, expDepth);
  endtask

  initial begin
    #400000;
    nFail++;
    nChecks++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
  end

  initial begin
    rstN = 1'b0; vpa = 1'b0; vda = 1'b0; rwN = 1'b1; streamData = 8'h02;
    repeat (3) @(negedge clk);
    #1;
    check(rdy && be && !busAddrEn && !cpuSubst, "R1 reset bus state", {28'h0, rdy, be, busAddrEn, cpuSubst}, 32'hC);
    check(stackDepth == 0 && !stackOverflow && stackTop == 0, "R1 reset stack", stackTop, 32'h0);
    @(negedge clk);
    rstN = 1'b1;
    drive(0, 0, 1, 8'h11);
    check(rdy && be && cpuDataOut == 8'h11, "R1 after reset", {24'h0, cpuDataOut}, 32'h11);

    for (int i = 0; i < 6; i++) runEscape(VEC[i][31:24], VEC[i][23:0], 1'b0);

    // R2: $02 on non-opcode-fetch cycles does not trigger
    drive(1, 0, 1, 8'h02);
    check(cpuDataOut == 8'h02 && !cpuSubst, "R2 operand fetch 02", {24'h0, cpuDataOut}, 32'h02);
    drive(0, 1, 1, 8'h02);
    check(cpuDataOut == 8'h02 && !cpuSubst, "R2 data read 02", {24'h0, cpuDataOut}, 32'h02);
    drive(1, 1, 0, 8'h02);
    check(!cpuSubst, "R2 write 02", {31'h0, cpuSubst}, 32'h0);
    drive(1, 0, 1, 8'h55);
    check(cpuDataOut == 8'h55 && !cpuSubst, "R2 no sequence started", {24'h0, cpuDataOut}, 32'h55);
    drive(1, 1, 1, 8'h55);
    check(rdy && cpuDataOut == 8'h55, "R2 still idle", {24'h0, cpuDataOut}, 32'h55);

    runEscape(8'h03, 24'hABCDEF, 1'b1);
    runEscape(8'h01, 24'h0000FE, 1'b0);
    check(!stackOverflow && stackDepth == 8, "R8 full without overflow", {28'h0, stackDepth}, 32'h8);
    runEscape(8'h03, 24'h222222, 1'b0);
    check(stackOverflow, "R8 overflow set", {31'h0, stackOverflow}, 32'h1);
    repeat (3) drive(0, 0, 1, 8'h00);
    check(stackOverflow && stackDepth == 8, "R8 overflow sticky", {31'h0, stackOverflow}, 32'h1);
    report();
  end
endmodule